// File: doc/BRIEF.md
# Dual-mode SPI serial port

A byte-wide synchronous serial port that can act as the clock-driving end of an SPI link or as the clock-following end. A 4-bit mode field in the control register picks the role and, for the clock-driving role, the SCK rate. One shift register moves the bits and one receive buffer holds the last complete byte. Software talks to the port over a small register bus. It has three registers: control, buffer and status.

In master role a write to the buffer starts an 8-bit exchange, MSB first. SCK is derived from the system clock by 4, 16 or 64, or it toggles once per pulse of an external timer tick. In slave role the port follows an SCK pin, which it synchronises to the system clock. Its select input is either honoured or ignored. Two sticky flags report misuse, and software clears them: a buffer write during a transfer, and a slave byte that arrives while the previous one is still unread.

Top module: `spi_dual_port`

Register map. Address 0 is control: bits [3:0] hold the mode, bit 4 holds the clock polarity and bit 5 holds the enable. Address 1 is the buffer: a write loads the transmit byte and a read returns the received byte. Address 2 is status: bit 0 is buffer-full, bit 1 is collision, bit 2 is overflow and bit 3 is busy. Writing a 1 to status bit 1 or bit 2 clears that flag.

## Requirements
- R1: Mode codes 0000, 0001 and 0010 run as master with an SCK period of 4, 16 and 64 system clocks.
- R2: Mode code 0011 runs as master, and SCK toggles once per `tmr_tick` pulse, so its period is twice the tick interval.
- R3: Transfers are 8 bits, MSB first. Data is sampled on the leading SCK edge, which is the edge that leaves the idle level, and shifted on the trailing edge. At the eighth sample the received byte enters the buffer and status bit 0 sets. A read of address 1 clears status bit 0. With SDO looped to SDI, a master transfer returns the byte that was sent.
- R4: Control bit 4 sets the SCK idle level: 1 gives idle high and 0 gives idle low. A master drives that level whenever no transfer is running.
- R5: Mode code 0100 is slave with the select input honoured. While `ss_n_i` is high, `sdo_oe` is 0, edges are ignored and the bit counter is held at zero. `ss_owned` is 1.
- R6: Mode code 0101 is slave with the select input ignored. Transfers proceed whatever the level of `ss_n_i`, `sdo_oe` is 1 and `ss_owned` is 0.
- R7: A buffer write while busy sets status bit 1 and is otherwise ignored. The flag stays set until a status write with bit 1 = 1 clears it.
- R8: In slave role, a byte that completes while status bit 0 is set sets status bit 2. That byte is dropped and the buffer keeps the old byte. A status write with bit 2 = 1 clears the flag.
- R9: In master role status bit 2 never sets. A new byte overwrites the buffer.
- R10: With control bit 5 = 0, or with a mode code above 0101, `pins_owned`, `sck_oe` and `sdo_oe` are 0 and a buffer write starts nothing.
- R11: After reset the control and status registers read 0 and every output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a buffer read clears buffer-full) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| tmr_tick | input | 1 | Timer pulse used as a master clock source |
| sck_i | input | 1 | SCK pin input (slave role) |
| sck_o | output | 1 | SCK pin output (master role) |
| sck_oe | output | 1 | SCK output enable |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | SDO output enable |
| ss_n_i | input | 1 | Slave select, active low |
| pins_owned | output | 1 | Serial port owns SCK/SDO/SDI/SS |
| ss_owned | output | 1 | SS pin is used as the select input |

## Verification
A wrong divider limit or tick source appears within one SCK period as a wrong spacing between SCK edges. A bit counter or shift register that is off by one corrupts the byte returned in loopback or from the slave's SDO, and this shows at the first buffer read after the transfer. Flag faults show in the status register right after the offending write or byte. A select that is not honoured shows as a byte that completes early after a partial, deselected transfer.

// File: rtl/spi_dual_port.sv
`timescale 1ns/1ps
module spi_dual_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          tmr_tick,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          sdo_oe,
  input  logic          ss_n_i,
  output logic          pins_owned,
  output logic          ss_owned
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  logic [3:0]    mode;
  logic          cpol, en;
  logic [DW-1:0] sr, rbuf;
  logic [CW-1:0] bitcnt;
  logic          half, xfer, rx_bit, full, coll, ovf;
  logic [4:0]    div_cnt, div_lim;
  logic [2:0]    sck_s;
  logic [1:0]    ss_s;

  wire is_master = (mode[3:2] == 2'b00);
  wire is_slave  = (mode == 4'd4) || (mode == 4'd5);
  wire active    = en && (is_master || is_slave);
  wire m_on      = active && is_master;
  wire s_on      = active && is_slave;
  wire ss_ctl    = (mode == 4'd4);
  wire s_desel   = s_on && ss_ctl && ss_s[1];
  wire s_sel     = s_on && !s_desel;

  always_comb
    case (mode[1:0])
      2'd0:    div_lim = 5'd1;
      2'd1:    div_lim = 5'd7;
      default: div_lim = 5'd31;
    endcase

  wire tick    = m_on && xfer && ((mode[1:0] == 2'b11) ? tmr_tick : (div_cnt == div_lim));
  wire sck_chg = sck_s[1] ^ sck_s[2];
  wire lead    = m_on ? (tick && !half) : (s_sel && sck_chg && (sck_s[1] != cpol));
  wire trail   = m_on ? (tick && half)  : (s_sel && sck_chg && (sck_s[1] == cpol) && half);
  wire last    = (bitcnt == CW'(DW-1));
  wire done    = lead && last;
  wire busy    = m_on ? xfer : (half || (bitcnt != '0));
  wire wr_ctl  = wr_en && (addr == 2'd0);
  wire wr_buf  = wr_en && (addr == 2'd1);
  wire wr_st   = wr_en && (addr == 2'd2);
  wire rd_buf  = rd_en && (addr == 2'd1);
  wire start   = wr_buf && active && !busy;
  wire collide = wr_buf && active && busy;
  wire drop    = done && s_on && full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {en, cpol, mode} <= '0;
      sck_s   <= '0;
      ss_s    <= 2'b11;
      div_cnt <= '0;
      xfer    <= 1'b0;
      half    <= 1'b0;
      bitcnt  <= '0;
      rx_bit  <= 1'b0;
      sr      <= '0;
      rbuf    <= '0;
      full    <= 1'b0;
      coll    <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      if (wr_ctl) {en, cpol, mode} <= wdata[5:0];
      sck_s <= {sck_s[1:0], sck_i};
      ss_s  <= {ss_s[0], ss_n_i};
      div_cnt <= (!xfer || tick || start) ? 5'd0 : div_cnt + 5'd1;

      if (!active || s_desel) begin
        xfer   <= 1'b0;
        half   <= 1'b0;
        bitcnt <= '0;
      end else begin
        if (start) xfer <= m_on;
        if (lead) begin
          half   <= 1'b1;
          rx_bit <= sdi_i;
        end
        if (trail) begin
          half   <= 1'b0;
          bitcnt <= last ? '0 : bitcnt + 1'b1;
          if (last) xfer <= 1'b0;
        end
      end

      if (start)      sr <= wdata[DW-1:0];
      else if (trail) sr <= {sr[DW-2:0], rx_bit};

      if (done && !drop) rbuf <= {sr[DW-2:0], sdi_i};

      if (done && !drop) full <= 1'b1;
      else if (rd_buf)   full <= 1'b0;

      if (collide)                coll <= 1'b1;
      else if (wr_st && wdata[1]) coll <= 1'b0;

      if (drop)                   ovf <= 1'b1;
      else if (wr_st && wdata[2]) ovf <= 1'b0;
    end

  always_comb
    case (addr)
      2'd0:    rdata = {2'b00, en, cpol, mode};
      2'd1:    rdata = 8'(rbuf);
      2'd2:    rdata = {4'b0000, busy, ovf, coll, full};
      default: rdata = 8'h00;
    endcase

  assign sck_o      = m_on ? (cpol ^ half) : cpol;
  assign sck_oe     = m_on;
  assign sdo_o      = sr[DW-1];
  assign sdo_oe     = m_on || s_sel;
  assign pins_owned = active;
  assign ss_owned   = s_on && ss_ctl;

  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_on && !xfer) |-> (sck_o == cpol)); // R4
  AST_NO_MASTER_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (m_on && !ovf) |=> !ovf); // R9
  AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (coll && !(wr_st && wdata[1])) |=> coll); // R7
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !busy); // R10
  AST_SS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    s_desel |=> ((bitcnt == '0) && !half)); // R5
  AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && !done) |=> !full); // R3
  AST_OVF_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> $stable(rbuf)); // R8
endmodule

// File: tb/spi_dual_port_bench.sv
`timescale 1ns/1ps
module spi_dual_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, rdata;
  logic tmr_tick = 1'b0, sck_b = 1'b0, sdi_b = 1'b0, ss_b = 1'b1, loop = 1'b0;
  logic sck_o, sck_oe, sdo_o, sdo_oe, pins_owned, ss_owned;
  wire  sdi_w = loop ? sdo_o : sdi_b;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  spi_dual_port u_spi_dual_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tmr_tick(tmr_tick), .sck_i(sck_b),
    .sck_o(sck_o), .sck_oe(sck_oe), .sdi_i(sdi_w), .sdo_o(sdo_o),
    .sdo_oe(sdo_oe), .ss_n_i(ss_b), .pins_owned(pins_owned), .ss_owned(ss_owned)
  );

  initial forever begin
    repeat (4) @(negedge clk);
    tmr_tick = 1'b1;
    @(negedge clk);
    tmr_tick = 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    do bus_rd(2'd2, s); while (s[3]);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic master_xfer(input logic [7:0] tx, output logic [7:0] rx);
    bus_wr(2'd1, tx);
    wait_idle();
    bus_rd(2'd1, rx);
  endtask

  task automatic slave_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk);
      sdi_b = tx[i];
      settle(8);
      rx[i] = sdo_o;
      sck_b = ~sck_b;
      settle(8);
      sck_b = ~sck_b;
    end
    settle(8);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_rd(2'd0, d); chk("R11 control", d, 8'h00);
    bus_rd(2'd2, d); chk("R11 status", d, 8'h00);
    chk("R11 enables", {sck_oe, sdo_oe, pins_owned}, 3'b000);
  endtask

  task automatic t_ratio(input logic [3:0] m, input longint exp_ns, input string req);
    longint t0, t1;
    logic [7:0] d;
    loop = 1'b1;
    bus_wr(2'd0, {4'b0010, m});
    bus_wr(2'd1, 8'h55);
    @(posedge sck_o); t0 = longint'($time);
    @(posedge sck_o); t1 = longint'($time);
    chk(req, 32'(t1 - t0), 32'(exp_ns));
    wait_idle();
    bus_rd(2'd1, d);
  endtask

  task automatic t_loopback();
    logic [7:0] rx, s;
    logic [7:0] bytes [4] = '{8'hA5, 8'h3C, 8'h81, 8'h7E};
    loop = 1'b1;
    for (int m = 0; m < 4; m++) begin
      bus_wr(2'd0, 8'h20 | 8'(m));
      bus_wr(2'd1, bytes[m]);
      wait_idle();
      bus_rd(2'd2, s); chk("R3 full after byte", s[0], 1'b1);
      bus_rd(2'd1, rx); chk("R3 loopback data", rx, bytes[m]);
      bus_rd(2'd2, s); chk("R3 full cleared by read", s[0], 1'b0);
    end
  endtask

  task automatic t_cpol();
    logic [7:0] rx;
    loop = 1'b1;
    bus_wr(2'd0, 8'h30); settle(2);
    chk("R4 idle high", {sck_oe, sck_o}, 2'b11);
    master_xfer(8'hC6, rx); chk("R4 data with idle high", rx, 8'hC6);
    chk("R4 idle high after", sck_o, 1'b1);
    bus_wr(2'd0, 8'h20); settle(2);
    chk("R4 idle low", sck_o, 1'b0);
  endtask

  task automatic t_collision();
    logic [7:0] s, rx;
    loop = 1'b1;
    bus_wr(2'd0, 8'h22);
    bus_wr(2'd1, 8'hA5);
    bus_wr(2'd1, 8'h3C);
    bus_rd(2'd2, s); chk("R7 collision set", s[1], 1'b1);
    wait_idle();
    bus_rd(2'd1, rx); chk("R7 colliding write ignored", rx, 8'hA5);
    bus_rd(2'd2, s); chk("R7 collision sticky", s[1], 1'b1);
    bus_wr(2'd2, 8'h02);
    bus_rd(2'd2, s); chk("R7 collision cleared", s[1], 1'b0);
  endtask

  task automatic t_master_no_ovf();
    logic [7:0] s, rx;
    loop = 1'b1;
    bus_wr(2'd0, 8'h20);
    bus_wr(2'd1, 8'h11); wait_idle();
    bus_wr(2'd1, 8'h22); wait_idle();
    bus_rd(2'd2, s); chk("R9 no overflow in master", s[2:0], 3'b001);
    bus_rd(2'd1, rx); chk("R9 buffer overwritten", rx, 8'h22);
  endtask

  task automatic t_slave_ss();
    logic [7:0] rx, s;
    loop = 1'b0;
    bus_wr(2'd0, 8'h00);
    sck_b = 1'b0; ss_b = 1'b1; settle(4);
    bus_wr(2'd0, 8'h24); settle(4);
    chk("R5 sdo off when deselected", sdo_oe, 1'b0);
    chk("R5 ss owned", ss_owned, 1'b1);
    bus_wr(2'd1, 8'hC3);
    ss_b = 1'b0; settle(4);
    chk("R5 sdo on when selected", sdo_oe, 1'b1);
    slave_bits(8'hFF, 3, rx);
    ss_b = 1'b1; settle(4);
    bus_rd(2'd2, s); chk("R5 counter reset by ss", s[3], 1'b0);
    bus_wr(2'd1, 8'h96);
    bus_rd(2'd2, s); chk("R5 no collision after reset", s[1], 1'b0);
    ss_b = 1'b0; settle(4);
    slave_bits(8'h5A, 8, rx);
    chk("R5 slave sdo data", rx, 8'h96);
    bus_rd(2'd1, rx); chk("R5 slave received byte", rx, 8'h5A);
    ss_b = 1'b1;
  endtask

  task automatic t_slave_noss();
    logic [7:0] rx;
    loop = 1'b0; ss_b = 1'b1;
    bus_wr(2'd0, 8'h25); settle(4);
    bus_wr(2'd1, 8'h3E);
    chk("R6 sdo on with ss high", sdo_oe, 1'b1);
    chk("R6 ss not owned", ss_owned, 1'b0);
    slave_bits(8'hA7, 8, rx);
    chk("R6 slave sdo data", rx, 8'h3E);
    bus_rd(2'd1, rx); chk("R6 slave received byte", rx, 8'hA7);
  endtask

  task automatic t_overflow();
    logic [7:0] rx, s;
    loop = 1'b0;
    bus_wr(2'd0, 8'h00);
    sck_b = 1'b1; settle(4);
    bus_wr(2'd0, 8'h35); settle(4);
    bus_wr(2'd1, 8'h00);
    slave_bits(8'h81, 8, rx);
    bus_rd(2'd2, s); chk("R8 no overflow on first byte", s[2], 1'b0);
    slave_bits(8'h7E, 8, rx);
    bus_rd(2'd2, s); chk("R8 overflow set", s[2], 1'b1);
    bus_rd(2'd1, rx); chk("R8 old byte kept", rx, 8'h81);
    bus_wr(2'd2, 8'h04);
    bus_rd(2'd2, s); chk("R8 overflow cleared", s[2], 1'b0);
    bus_wr(2'd0, 8'h00);
    sck_b = 1'b0; settle(4);
  endtask

  task automatic t_inactive(input logic [7:0] ctl, input string req);
    logic [7:0] s;
    bus_wr(2'd0, ctl);
    bus_wr(2'd1, 8'h5A);
    settle(40);
    chk(req, {pins_owned, sck_oe, sdo_oe}, 3'b000);
    bus_rd(2'd2, s); chk(req, {s[3], s[0]}, 2'b00);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(2);
    t_reset();
    t_ratio(4'd0, 40, "R1 divide by 4");
    t_ratio(4'd1, 160, "R1 divide by 16");
    t_ratio(4'd2, 640, "R1 divide by 64");
    t_ratio(4'd3, 100, "R2 timer tick halved");
    t_loopback();
    t_cpol();
    t_collision();
    t_master_no_ovf();
    t_slave_ss();
    t_slave_noss();
    t_overflow();
    t_inactive(8'h00, "R10 disabled");
    t_inactive(8'h26, "R10 reserved mode");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule